// File: doc/BRIEF.md
# Three-Segment Multiply-Add Pipeline

This block computes A*B + C for a stream of unsigned operand triples and accepts one triple on every clock without stalling. The work is spread over three register segments. The first captures A and B. The second forms their product and captures C next to it. The third adds the two and registers the result. A valid bit travels with each item, so the output flag marks only real results.

The product is twice the operand width. The sum has one extra bit, so no operand combination can overflow. By default, C arrives one clock after its A and B and goes straight into the second segment, where it lines up with the product. A build option takes all three operands in the same cycle instead. In that case C passes through one extra register in the first segment.

Top module: `madd_pipe`

## Requirements
- R1: A synchronous active-high reset clears the valid bits of all three segments. out_valid stays low while reset is held and for the first three clocks after it is released.
- R2: For every accepted item, out_sum equals A*B + C as an unsigned value that is 2*W+1 bits wide.
- R3: An item accepted at clock edge k, which needs in_valid high before that edge, shows its result with out_valid high after edge k+2. Counting the accepting edge as the first, that is the end of the third clock.
- R4: Items may arrive on consecutive clocks. For seven back-to-back items, the first result appears at the end of clock 3 and the last at the end of clock 9, with out_valid high in every clock between.
- R5: With C_MODE = 0 (late C, the default), in_c is sampled on the clock after its A and B are accepted. The value in_c holds during the A/B cycle has no effect on that item.
- R6: With C_MODE = 1 (joined), in_c is sampled in the same cycle as in_a and in_b, and the latency stays as in R3.
- R7: out_valid is high only in the cycles that carry the result of an accepted item. A cycle with in_valid low produces no result, whatever in_a, in_b and in_c hold.
- R8: After the last accepted item, the pipe drains in two more clocks. out_valid falls on the clock after the final result.
- R9: With all-ones operands, the result is (2^W-1)^2 + (2^W-1) and does not wrap.
- R10: A reset applied while items are in flight discards them, and none of them reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A and B are presented this cycle |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_c | input | W | Addend, timed as set by C_MODE |
| out_valid | output | 1 | out_sum carries a result |
| out_sum | output | 2*W+1 | A*B + C |

## Verification
In the same clock, the second segment captures one item's C while the first segment takes the next item's A and B from the same ports. The bench provokes this by running the full A×B sweep back to back. In the late-C instance, in_c always holds the previous item's addend while the new A and B are on the bus. Every output cycle is compared against a sum computed arithmetically in the bench. A second instance receives aligned operands and must produce identical results in identical cycles.

// File: rtl/madd_pkg.sv
package madd_pkg;

    typedef enum logic {
        C_LATE   = 1'b0,
        C_JOINED = 1'b1
    } c_mode_e;

    function automatic int prod_width(input int w);
        return 2 * w;
    endfunction

    function automatic int sum_width(input int w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/madd_seg_load.sv
module madd_seg_load
    import madd_pkg::*;
#(
    parameter int W      = 8,
    parameter int C_MODE = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic         s1_valid,
    output logic [W-1:0] s1_a,
    output logic [W-1:0] s1_b,
    output logic [W-1:0] s1_c
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_a <= in_a;
            s1_b <= in_b;
        end
    end

    generate
        if (c_mode_e'(C_MODE) == C_JOINED) begin : g_c_joined
            logic [W-1:0] c_hold;
            always_ff @(posedge clk) begin
                if (in_valid) begin
                    c_hold <= in_c;
                end
            end
            assign s1_c = c_hold;
        end else begin : g_c_late
            assign s1_c = in_c;
        end
    endgenerate

    AST_S1_TRACK: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid); // R4

endmodule

// File: rtl/madd_seg_mul.sv
module madd_seg_mul
    import madd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s1_valid,
    input  logic [W-1:0]              s1_a,
    input  logic [W-1:0]              s1_b,
    input  logic [W-1:0]              s1_c,
    output logic                      s2_valid,
    output logic [prod_width(W)-1:0]  s2_prod,
    output logic [W-1:0]              s2_c
);

    localparam int PW = prod_width(W);
    localparam logic [PW-1:0] OP_MAX   = {{W{1'b0}}, {W{1'b1}}};
    localparam logic [PW-1:0] PROD_MAX = OP_MAX * OP_MAX;

    logic [PW-1:0] prod_d;
    assign prod_d = PW'(s1_a) * PW'(s1_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            s2_prod <= prod_d;
            s2_c    <= s1_c;
        end
    end

    AST_PROD_BOUND: assert property (@(posedge clk) disable iff (rst)
        s2_valid |-> (s2_prod <= PROD_MAX)); // R9

endmodule

// File: rtl/madd_seg_add.sv
module madd_seg_add
    import madd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s2_valid,
    input  logic [prod_width(W)-1:0]  s2_prod,
    input  logic [W-1:0]              s2_c,
    output logic                      s3_valid,
    output logic [sum_width(W)-1:0]   s3_sum
);

    localparam int PW = prod_width(W);
    localparam int SW = sum_width(W);
    localparam logic [SW-1:0] OP_MAX  = SW'({W{1'b1}});
    localparam logic [SW-1:0] SUM_MAX = OP_MAX * OP_MAX + OP_MAX;

    logic [SW-1:0] sum_d;
    assign sum_d = SW'(s2_prod) + SW'(s2_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_valid <= 1'b0;
        end else begin
            s3_valid <= s2_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s2_valid) begin
            s3_sum <= sum_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        s3_valid |-> (s3_sum <= SUM_MAX)); // R9

    AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (rst)
        s2_valid |=> (s3_sum >= SW'($past(s2_c)))); // R2

    AST_SUM_PROD: assert property (@(posedge clk) disable iff (rst)
        s2_valid |=> (s3_sum >= SW'($past(s2_prod)))); // R2

endmodule

// File: rtl/madd_pipe.sv
module madd_pipe
    import madd_pkg::*;
#(
    parameter int W      = 8,
    parameter int C_MODE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [W-1:0]          in_a,
    input  logic [W-1:0]          in_b,
    input  logic [W-1:0]          in_c,
    output logic                  out_valid,
    output logic [2*W:0]          out_sum
);

    localparam int PW = prod_width(W);
    localparam int SW = sum_width(W);

    logic          s1_valid;
    logic [W-1:0]  s1_a;
    logic [W-1:0]  s1_b;
    logic [W-1:0]  s1_c;
    logic          s2_valid;
    logic [PW-1:0] s2_prod;
    logic [W-1:0]  s2_c;
    logic [SW-1:0] s3_sum;

    madd_seg_load #(.W(W), .C_MODE(C_MODE)) u_load (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_c     (in_c),
        .s1_valid (s1_valid),
        .s1_a     (s1_a),
        .s1_b     (s1_b),
        .s1_c     (s1_c)
    );

    madd_seg_mul #(.W(W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_a     (s1_a),
        .s1_b     (s1_b),
        .s1_c     (s1_c),
        .s2_valid (s2_valid),
        .s2_prod  (s2_prod),
        .s2_c     (s2_c)
    );

    madd_seg_add #(.W(W)) u_add (
        .clk      (clk),
        .rst      (rst),
        .s2_valid (s2_valid),
        .s2_prod  (s2_prod),
        .s2_c     (s2_c),
        .s3_valid (out_valid),
        .s3_sum   (s3_sum)
    );

    assign out_sum = s3_sum;

    // clocks since reset, saturating at 3, for the latency checks
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd3) |-> !out_valid); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ((age_q == 2'd3) && $past(in_valid, 3)) |-> out_valid); // R3

    AST_NO_GHOST: assert property (@(posedge clk) disable iff (rst)
        ((age_q == 2'd3) && out_valid) |-> $past(in_valid, 3)); // R7

endmodule

// File: tb/sim_madd_pipe.sv
module sim_madd_pipe;

    localparam int W  = 4;
    localparam int SW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic [W-1:0]  c_late = '0;
    logic [W-1:0]  c_join = '0;
    logic          v0;
    logic          v1;
    logic [SW-1:0] s0;
    logic [SW-1:0] s1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    string tag = "R1";

    logic          exp_v [8];
    logic [SW-1:0] exp_s [8];
    logic [W-1:0]  pend_c = '0;

    always #10 clk = ~clk;  // 50 MHz

    madd_pipe #(.W(W), .C_MODE(0)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(c_late), .out_valid(v0), .out_sum(s0)
    );

    madd_pipe #(.W(W), .C_MODE(1)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(c_join), .out_valid(v1), .out_sum(s1)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_one(input string who, input logic v, input logic [SW-1:0] s,
                             input logic ev, input logic [SW-1:0] es);
        total++;
        if (v !== ev || (ev && s !== es)) begin
            bad++;
            $display("FAIL %s %s cyc=%0d: valid=%b sum=%0d expected valid=%b sum=%0d",
                     tag, who, cyc, v, s, ev, es);
        end
    endtask

    // output checker: slot cyc%8 holds what must be on the outputs now
    always @(negedge clk) begin
        if (cyc > 0) begin
            check_one("late-C", v0, s0, exp_v[cyc % 8], exp_s[cyc % 8]);
            check_one("joined", v1, s1, exp_v[cyc % 8], exp_s[cyc % 8]);
            exp_v[cyc % 8] = 1'b0;
        end
    end

    task automatic clear_exp();
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = 1'b0;
            exp_s[i] = '0;
        end
    endtask

    // one clock of stimulus; late-C instance gets the previous item's C
    task automatic step(input logic v, input int a, input int b, input int c);
        @(negedge clk);
        in_valid = v;
        in_a     = W'(a);
        in_b     = W'(b);
        c_join   = W'(c);
        c_late   = pend_c;
        pend_c   = W'(c);
        if (v) begin
            exp_v[(cyc + 3) % 8] = 1'b1;
            exp_s[(cyc + 3) % 8] = SW'(a) * SW'(b) + SW'(c);
        end
    endtask

    // idle clocks; late C keeps the pending addend for one cycle, then junk
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, (i * 5) % 16, (i * 11) % 16, (i * 13 + 7) % 16);
    endtask

    task automatic do_reset(input int hold);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1 clear_exp();
        repeat (hold) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        clear_exp();
        // R1: reset state and warm-up
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(4);

        // R3: isolated item, 3*5+7 = 22
        tag = "R3";
        step(1'b1, 3, 5, 7);
        idle(5);

        // R4 / R8: seven back-to-back items then drain
        tag = "R4";
        for (int i = 1; i <= 7; i++) step(1'b1, i, i + 2, 15 - i);
        tag = "R8";
        idle(5);

        // R2 / R5 / R6: exhaustive A x B, back to back, C varying
        tag = "R2_R5_R6";
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                step(1'b1, a, b, (a + 3 * b + 1) % 16);
        idle(4);

        // R7: bubbles with junk on the data ports
        tag = "R7";
        for (int i = 0; i < 60; i++)
            step(((i * 7) % 3) != 0, (i * 3) % 16, (i * 5 + 1) % 16, (i * 9 + 2) % 16);
        idle(4);

        // R9: all-ones operands, 15*15+15 = 240
        tag = "R9";
        step(1'b1, 15, 15, 15);
        step(1'b1, 15, 15, 0);
        step(1'b1, 0, 15, 15);
        idle(4);

        // R10: reset with items in flight
        tag = "R10";
        step(1'b1, 9, 9, 9);
        step(1'b1, 10, 11, 12);
        step(1'b1, 13, 14, 15);
        do_reset(2);
        idle(6);
        step(1'b1, 2, 7, 1);
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, expected end before 20000 cycles");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule